// File: doc/BRIEF.md
# Weak-Indication Dual-Rail Ripple Adder

This block adds two WIDTH-bit operands and a carry-in, with every bit carried on a pair of wires. The `one` wire high means logic 1 and the `zero` wire high means logic 0. Both wires low is the empty (spacer) state, and both high is never legal. Each bit cell is a full adder. Its sum rails are built from three-input state-holding rendezvous gates: a gate of this kind drives 1 when all its inputs are 1, drives 0 when all are 0, and otherwise keeps its value. Its carry rails are plain AND/OR logic. The cells are chained as a ripple adder.

Time is modelled in discrete steps. Every state-holding gate and every carry gate updates on a rising edge of `clk`, so one clock edge stands for one gate delay. Latency is therefore visible as a count of edges, and it depends on the data. A cell whose operands are both 1 (generate) or both 0 (kill) settles its carry one step after the operands arrive, without waiting for its carry-in. A cell whose operands differ passes its carry-in through. Only the sum rails need every input to be present.

The block talks to a sender through a four-phase return-to-zero handshake, and the sender provides the back-pressure. The sender presents valid operands and carry-in and holds them until `ack` rises. `ack` rises only when every sum pair and the carry-out pair are valid. The sender then returns all inputs to spacer and waits for `ack` to fall, which happens only when every output pair is empty. New data may be presented only after that.

Top module: `dra_ripple_adder`

## Requirements
- R1: While `rst_n` is low, every output rail and `ack` are 0. This includes a reset asserted in the middle of a transaction.
- R2: When `ack` is high and all inputs are valid, the `one` rails of {cout, sum} equal a + b + cin, and each `zero` rail is the complement of its `one` rail.
- R3: No output pair (any sum bit or the carry-out) ever has both rails high.
- R4: `ack` rises only when all WIDTH+1 output pairs are valid. It falls only when all of them are spacer. When some pairs are valid and others are spacer, `ack` keeps its value.
- R5: A top bit with both operands 1 drives `cout_one` high one edge after the operands arrive, even while the carry-in is still spacer. Both operands 0 drive `cout_zero` high in the same way. While the carry-in is spacer, sum bit 0 stays spacer and `ack` stays low.
- R6: Completion latency depends on the data. With every bit propagating (operands differ in every bit), the carry-out settles after WIDTH edges and `ack` rises after WIDTH+1 edges. With every bit generating or every bit killing, `ack` rises after 3 edges.
- R7: After all inputs return to spacer, every output pair is spacer within 2 edges and `ack` falls on edge 3, whatever the value of WIDTH.
- R8: If only the carry-in returns to spacer while the operands are held, the sum rails keep their values and `ack` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gate-delay step clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all gate state to spacer |
| op_a_one | input | WIDTH | Operand A, logic-1 rails |
| op_a_zero | input | WIDTH | Operand A, logic-0 rails |
| op_b_one | input | WIDTH | Operand B, logic-1 rails |
| op_b_zero | input | WIDTH | Operand B, logic-0 rails |
| cin_one | input | 1 | Carry-in, logic-1 rail |
| cin_zero | input | 1 | Carry-in, logic-0 rail |
| sum_one | output | WIDTH | Sum, logic-1 rails |
| sum_zero | output | WIDTH | Sum, logic-0 rails |
| cout_one | output | 1 | Overflow carry, logic-1 rail |
| cout_zero | output | 1 | Overflow carry, logic-0 rail |
| ack | output | 1 | Handshake acknowledge from the completion detector |

## Verification
If a rendezvous gate is stuck or loses its held value, the fault reaches the ports in one of two ways. A sum pair can show both rails high, which is caught on the next edge. Otherwise `ack` can rise or fall while some pairs are still in the wrong phase, so the wrong state shows up in the same transaction. A fault in the carry chain shows up as a wrong decoded sum once `ack` rises. It can also show up as an `ack` edge on the wrong cycle, because the bench counts edges exactly for the full-propagate, all-generate and return-to-spacer cases. Carry-in withdrawal, and a carry-in that arrives late after the operands, exercise the hold behaviour of the sum gates and of the detector.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef struct packed {
    logic one;
    logic zero;
  } dr_bit_t;
endpackage

// File: rtl/dra_celem.sv
// State-holding rendezvous gate: sets when every input is high,
// clears when every input is low, otherwise keeps its value.
module dra_celem #(
  parameter int IN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IN-1:0] in_rails,
  output logic          q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           q <= 1'b0;
    else if (&in_rails)   q <= 1'b1;
    else if (~|in_rails)  q <= 1'b0;
  end
endmodule

// File: rtl/dra_fa_cell.sv
// One weakly indicating dual-rail full-adder cell.
module dra_fa_cell
  import dra_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dr_bit_t a,
  input  dr_bit_t b,
  input  dr_bit_t ci,
  output dr_bit_t s,
  output dr_bit_t co
);
  localparam int MINTERMS = 8;

  logic [MINTERMS-1:0] hit_odd;
  logic [MINTERMS-1:0] hit_even;

  // One rendezvous gate per input combination; each sum rail ORs
  // the gates whose combination has the matching parity.
  for (genvar m = 0; m < MINTERMS; m++) begin : g_min
    localparam logic [2:0] SEL = m[2:0];
    localparam bit ODD = SEL[2] ^ SEL[1] ^ SEL[0];
    logic [2:0] pick;
    logic       hit;
    assign pick = {SEL[2] ? a.one  : a.zero,
                   SEL[1] ? b.one  : b.zero,
                   SEL[0] ? ci.one : ci.zero};
    dra_celem #(.IN(3)) u_min (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_rails (pick),
      .q        (hit)
    );
    assign hit_odd[m]  = ODD  ? hit : 1'b0;
    assign hit_even[m] = !ODD ? hit : 1'b0;
  end

  assign s.one  = |hit_odd;
  assign s.zero = |hit_even;

  // Carry: generate/kill resolves without ci; the propagate term is
  // gated by the operand rails so the carry clears as soon as they do.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co <= '0;
    end else begin
      co.one  <= (a.one  & b.one)  | ((a.one  | b.one)  & ci.one);
      co.zero <= (a.zero & b.zero) | ((a.zero | b.zero) & ci.zero);
    end
  end
endmodule

// File: rtl/dra_done_detect.sv
// Completion detector: a pair is present when either rail is high;
// acknowledge follows a rendezvous over all pairs.
module dra_done_detect #(
  parameter int PAIRS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAIRS-1:0] rail_one,
  input  logic [PAIRS-1:0] rail_zero,
  output logic             done
);
  logic [PAIRS-1:0] present;
  assign present = rail_one | rail_zero;

  dra_celem #(.IN(PAIRS)) u_all (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_rails (present),
    .q        (done)
  );
endmodule

// File: rtl/dra_ripple_adder.sv
module dra_ripple_adder
  import dra_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a_one,
  input  logic [WIDTH-1:0] op_a_zero,
  input  logic [WIDTH-1:0] op_b_one,
  input  logic [WIDTH-1:0] op_b_zero,
  input  logic             cin_one,
  input  logic             cin_zero,
  output logic [WIDTH-1:0] sum_one,
  output logic [WIDTH-1:0] sum_zero,
  output logic             cout_one,
  output logic             cout_zero,
  output logic             ack
);
  localparam int PAIRS = WIDTH + 1;

  dr_bit_t carry [WIDTH+1];
  dr_bit_t sum_bit [WIDTH];

  assign carry[0] = '{one: cin_one, zero: cin_zero};

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    dra_fa_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .a     ('{one: op_a_one[k], zero: op_a_zero[k]}),
      .b     ('{one: op_b_one[k], zero: op_b_zero[k]}),
      .ci    (carry[k]),
      .s     (sum_bit[k]),
      .co    (carry[k+1])
    );
    assign sum_one[k]  = sum_bit[k].one;
    assign sum_zero[k] = sum_bit[k].zero;
  end

  assign cout_one  = carry[WIDTH].one;
  assign cout_zero = carry[WIDTH].zero;

  dra_done_detect #(.PAIRS(PAIRS)) u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_one  ({cout_one, sum_one}),
    .rail_zero ({cout_zero, sum_zero}),
    .done      (ack)
  );
endmodule

// File: rtl/dra_ripple_adder_chk.sv
module dra_ripple_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a_one,
  input logic [WIDTH-1:0] op_a_zero,
  input logic [WIDTH-1:0] op_b_one,
  input logic [WIDTH-1:0] op_b_zero,
  input logic             cin_one,
  input logic             cin_zero,
  input logic [WIDTH-1:0] sum_one,
  input logic [WIDTH-1:0] sum_zero,
  input logic             cout_one,
  input logic             cout_zero,
  input logic             ack
);
  logic             outs_valid, outs_empty, ins_valid;
  logic [WIDTH:0]   ref_total;

  assign outs_valid = (&(sum_one | sum_zero)) & (cout_one | cout_zero);
  assign outs_empty = ~|{sum_one, sum_zero, cout_one, cout_zero};
  assign ins_valid  = (&(op_a_one | op_a_zero)) & (&(op_b_one | op_b_zero))
                      & (cin_one | cin_zero);
  assign ref_total  = {1'b0, op_a_one} + {1'b0, op_b_one} + {{WIDTH{1'b0}}, cin_one};

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ins_valid |-> ({cout_one, sum_one} == ref_total) && (sum_zero == ~sum_one)); // R2
  AST_RAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sum_one & sum_zero)) && !(cout_one && cout_zero)); // R3
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> outs_valid); // R4
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> outs_empty); // R4
  AST_GEN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    op_a_one[WIDTH-1] && op_b_one[WIDTH-1] |=> cout_one); // R5
  AST_KILL_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    op_a_zero[WIDTH-1] && op_b_zero[WIDTH-1] |=> cout_zero); // R5
endmodule

bind dra_ripple_adder dra_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .op_a_one(op_a_one), .op_a_zero(op_a_zero),
  .op_b_one(op_b_one), .op_b_zero(op_b_zero),
  .cin_one(cin_one), .cin_zero(cin_zero),
  .sum_one(sum_one), .sum_zero(sum_zero),
  .cout_one(cout_one), .cout_zero(cout_zero),
  .ack(ack)
);

// File: tb/dra_ripple_adder_bench.sv
`timescale 1ns/1ps
module dra_ripple_adder_bench;
  localparam int W = 8;
  localparam int LIMIT = 4 * W + 10;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    '{8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    '{8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    '{8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
    '{8'h55, 8'hAA, 1'b1, 8'h00, 1'b1},
    '{8'h12, 8'h34, 1'b0, 8'h46, 1'b0},
    '{8'h7F, 8'h7F, 1'b1, 8'hFF, 1'b0},
    '{8'hC3, 8'h3C, 1'b0, 8'hFF, 1'b0},
    '{8'hA5, 8'h5A, 1'b1, 8'h00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_one = '0, a_zero = '0, b_one = '0, b_zero = '0;
  logic ci_one = 1'b0, ci_zero = 1'b0;
  logic [W-1:0] sum_one, sum_zero;
  logic cout_one, cout_zero, ack;

  int checks = 0;
  int errors = 0;
  int rail_clash = 0;

  always #2.5 clk = ~clk;

  dra_ripple_adder #(.WIDTH(W)) u_dra_ripple_adder (
    .clk(clk), .rst_n(rst_n),
    .op_a_one(a_one), .op_a_zero(a_zero),
    .op_b_one(b_one), .op_b_zero(b_zero),
    .cin_one(ci_one), .cin_zero(ci_zero),
    .sum_one(sum_one), .sum_zero(sum_zero),
    .cout_one(cout_one), .cout_zero(cout_zero),
    .ack(ack)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    a_one = a; a_zero = ~a; b_one = b; b_zero = ~b;
  endtask

  task automatic put_cin(input logic c);
    ci_one = c; ci_zero = ~c;
  endtask

  task automatic put_empty();
    a_one = '0; a_zero = '0; b_one = '0; b_zero = '0;
    ci_one = 1'b0; ci_zero = 1'b0;
  endtask

  task automatic wait_ack(input logic level, input string req);
    for (int i = 0; i < LIMIT; i++) begin
      if (ack == level) break;
      @(negedge clk);
    end
    chk(req, ack, level);
  endtask

  task automatic outputs_empty(input string req);
    chk(req, {cout_one, cout_zero, sum_one, sum_zero}, '0);
  endtask

  task automatic transact(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                          input logic [W-1:0] s, input logic co);
    put_ops(a, b); put_cin(c);
    @(negedge clk);
    wait_ack(1'b1, "R4 ack rise");
    chk("R2 sum", {cout_one, sum_one}, {co, s});
    chk("R2 zero rails", {cout_zero, sum_zero}, {~co, ~s});
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R4 ack fall");
    outputs_empty("R4 empty at ack low");
  endtask

  // R3: no output pair may ever show both rails high
  always @(negedge clk) begin
    if (rst_n && ((|(sum_one & sum_zero)) || (cout_one && cout_zero))) rail_clash++;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    outputs_empty("R1 reset rails");
    chk("R1 reset ack", ack, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: table walk
    for (int i = 0; i < NV; i++)
      transact(VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].s, VECS[i].co);

    // R2: random operands against binary reference
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      logic [W:0] tot;
      ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
      tot = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      transact(ra, rb, rc, tot[W-1:0], tot[W]);
    end

    // R6: full propagate, exact edge counts; then R7 return to spacer
    put_ops(8'hFF, 8'h00); put_cin(1'b1);
    repeat (W) @(negedge clk);
    chk("R6 propagate ack not yet", ack, 1'b0);
    chk("R6 propagate cout settled", {cout_one, cout_zero}, 2'b10);
    @(negedge clk);
    chk("R6 propagate ack at W+1", ack, 1'b1);
    chk("R6 propagate sum", sum_one, 8'h00);
    put_empty();
    repeat (2) @(negedge clk);
    outputs_empty("R7 empty after 2 edges");
    chk("R7 ack held at edge 2", ack, 1'b1);
    @(negedge clk);
    chk("R7 ack low at edge 3", ack, 1'b0);

    // R6: all generate settles in 3 edges
    put_ops(8'hFF, 8'hFF); put_cin(1'b0);
    repeat (2) @(negedge clk);
    chk("R6 generate ack not yet", ack, 1'b0);
    @(negedge clk);
    chk("R6 generate ack at 3", ack, 1'b1);
    chk("R6 generate sum", {cout_one, sum_one}, {1'b1, 8'hFE});
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R7 ack fall");

    // R6: all kill settles in 3 edges
    put_ops(8'h00, 8'h00); put_cin(1'b1);
    repeat (3) @(negedge clk);
    chk("R6 kill ack at 3", ack, 1'b1);
    chk("R6 kill sum", {cout_zero, sum_one}, {1'b1, 8'h01});
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R7 ack fall");

    // R5: top generate resolves before cin arrives
    put_ops(8'h80, 8'h80);
    @(negedge clk);
    chk("R5 early cout_one", {cout_one, cout_zero}, 2'b10);
    repeat (W) @(negedge clk);
    chk("R5 bit0 sum waits for cin", {sum_one[0], sum_zero[0]}, 2'b00);
    chk("R5 ack waits for cin", ack, 1'b0);
    put_cin(1'b1);
    @(negedge clk);
    wait_ack(1'b1, "R5 ack after cin");
    chk("R5 late cin sum", {cout_one, sum_one}, {1'b1, 8'h01});
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R5 ack fall");

    // R5: top kill resolves before cin arrives
    put_ops(8'h01, 8'h01);
    @(negedge clk);
    chk("R5 early cout_zero", {cout_one, cout_zero}, 2'b01);
    put_cin(1'b0);
    @(negedge clk);
    wait_ack(1'b1, "R5 kill ack");
    chk("R5 kill sum", {cout_one, sum_one}, {1'b0, 8'h02});
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R5 kill ack fall");

    // R8: withdraw only cin; sums and ack hold
    put_ops(8'h12, 8'h34); put_cin(1'b0);
    @(negedge clk);
    wait_ack(1'b1, "R8 ack rise");
    ci_one = 1'b0; ci_zero = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 sum held", {sum_one, sum_zero}, {8'h46, 8'hB9});
    chk("R8 ack held", ack, 1'b1);
    put_empty();
    @(negedge clk);
    wait_ack(1'b0, "R8 ack fall");
    outputs_empty("R8 empty");

    // R1: reset mid-transaction
    put_ops(8'h0F, 8'h01); put_cin(1'b0);
    @(negedge clk);
    wait_ack(1'b1, "R1 pre-reset ack");
    rst_n = 1'b0;
    #1;
    outputs_empty("R1 async reset rails");
    chk("R1 async reset ack", ack, 1'b0);
    put_empty();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    transact(8'h0F, 8'h01, 1'b0, 8'h10, 1'b0);

    chk("R3 rail exclusivity", rail_clash, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule